// File: doc/BRIEF.md
# Host Port Interrupt Request Generator

This block sits between a host processor's register bus and a core-side engine. It carries two data paths, each with four 16-bit word slots. On the transmit path the host fills the slots and the core takes the whole frame. On the receive path the core pushes a frame and the host reads it out word by word. The block tracks a transmit-empty flag and a receive-full flag. It turns them into active-low request pins that drive the host's interrupt inputs.

A control word chooses how the requests reach the pins. In double request mode the transmit and receive requests each have their own pin, and each has its own enable. Otherwise both enabled requests are merged onto the first pin. The host's service routine reads the status word to find out which request is pending. It clears the request by touching the data slots: a write of the last transmit slot, or a read of the last receive slot. No status register has to be written.

Top module: `host_req_port`

## Requirements
- R1: After reset the transmit-empty flag is 1 and the receive-full flag is 0. The control word is 0. Both request pins are high, `coreTxValid` is 0 and `coreRxReady` is 1.
- R2: Host address 0 is the control word and address 1 is the status word. Control bit 13 selects double mode, bit 14 enables the transmit request and bit 15 enables the receive request. Status bit 14 is transmit-empty and bit 15 is receive-full. All other bits read as 0. Read data appears on `hostRdata` one clock after the read strobe.
- R3: Addresses 4 to 7 select data slot 0 to 3 (address bit 2 set, low bits give the index). A host write there while transmit-empty is 1 stores the word. A write of slot 3 also clears transmit-empty. `coreTxValid` is the inverse of transmit-empty, and `coreTxData` holds slot i at bits [16i+15:16i].
- R4: A core take while `coreTxValid` is 1 sets transmit-empty.
- R5: A host write to a transmit slot while transmit-empty is 0 is ignored. Neither `coreTxData` nor the flag changes.
- R6: A core push while receive-full is 0 loads all four receive slots from `coreRxData` (same lane layout as R3) and sets receive-full. A host read of slot i returns word i. A read of slot 3 clears receive-full.
- R7: A core push while receive-full is 1 is refused. The slot contents and the flag stay unchanged.
- R8: In double mode, `reqTxN` is low exactly when the transmit enable and transmit-empty are both 1. The pin changes one clock after the flag or the enable changes.
- R9: In double mode, `reqRxN` is low exactly when the receive enable and receive-full are both 1. With both enables clear, both pins stay high.
- R10: Outside double mode, `reqTxN` is low when either enabled request is active, and `reqRxN` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hostSel | input | 1 | Host access strobe |
| hostWr | input | 1 | 1 = write, 0 = read |
| hostAddr | input | 3 | Host register address |
| hostWdata | input | 16 | Host write data |
| hostRdata | output | 16 | Registered host read data |
| coreTxValid | output | 1 | Transmit frame ready for the core |
| coreTxData | output | 64 | Transmit slots, flattened |
| coreTxTake | input | 1 | Core takes the transmit frame |
| coreRxReady | output | 1 | Receive slots free for a push |
| coreRxData | input | 64 | Receive frame from the core, flattened |
| coreRxPush | input | 1 | Core pushes a receive frame |
| reqTxN | output | 1 | Transmit request pin (or merged request), active low |
| reqRxN | output | 1 | Receive request pin, active low |

## Verification
The hardest situation to reach is each pairing of control setting and flag state, held long enough for the registered pin to settle. The flags move only as side effects of host slot accesses and core handshakes. The bench therefore steers each flag to its target with the minimal access: a write of the last transmit slot or a core take, and a core push or a read of the last receive slot. It then sweeps all eight control settings against all four flag states and checks both pins one clock later. The refused push and the ignored write are set up by first filling the path and then repeating the access with a different data pattern.

// File: rtl/host_req_pkg.sv
package host_req_pkg;
  // Strobes from the control side to the datapath.
  typedef struct packed {
    logic txWrite;  // store host word into the addressed transmit slot
    logic rxLoad;   // capture a full frame into the receive slots
    logic rdSlot;   // return the addressed receive slot
    logic rdCtrl;   // return the control word
    logic rdStat;   // return the status word
  } dpStrobe_t;

  localparam int DBL_BIT  = 13;
  localparam int TXEN_BIT = 14;
  localparam int RXEN_BIT = 15;
  localparam int TXE_BIT  = 14;
  localparam int RXF_BIT  = 15;
endpackage

// File: rtl/host_req_ctrl.sv
module host_req_ctrl
  import host_req_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SLOTS  = 4,
  localparam int IDX_W  = $clog2(SLOTS),
  localparam int ADDR_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostSel,
  input  logic              hostWr,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [2:0]        ctrlBits,
  input  logic              coreTxTake,
  input  logic              coreRxPush,
  output dpStrobe_t         strobe,
  output logic [DATA_W-1:0] ctrlWord,
  output logic [DATA_W-1:0] statWord,
  output logic              dblMode,
  output logic              txEn,
  output logic              rxEn,
  output logic              txEmpty,
  output logic              rxFull,
  output logic              reqTxN,
  output logic              reqRxN
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SLOTS - 1);

  logic             isData;
  logic [IDX_W-1:0] slotIdx;
  logic             isCtrl;
  logic             isStat;
  logic             txAccept;
  logic             txCommit;
  logic             rxRelease;
  logic             takeOk;
  logic             pushOk;
  logic             txReq;
  logic             rxReq;

  assign isData  = hostAddr[ADDR_W-1];
  assign slotIdx = hostAddr[IDX_W-1:0];
  assign isCtrl  = !isData && (slotIdx == '0);
  assign isStat  = !isData && (slotIdx == IDX_W'(1));

  assign txAccept  = hostSel && hostWr && isData && txEmpty;
  assign txCommit  = txAccept && (slotIdx == LAST_IDX);
  assign rxRelease = hostSel && !hostWr && isData && rxFull && (slotIdx == LAST_IDX);
  assign takeOk    = coreTxTake && !txEmpty;
  assign pushOk    = coreRxPush && !rxFull;

  always_comb begin
    strobe         = '0;
    strobe.txWrite = txAccept;
    strobe.rxLoad  = pushOk;
    strobe.rdSlot  = hostSel && !hostWr && isData;
    strobe.rdCtrl  = hostSel && !hostWr && isCtrl;
    strobe.rdStat  = hostSel && !hostWr && isStat;
  end

  // Control word.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dblMode <= 1'b0;
      txEn    <= 1'b0;
      rxEn    <= 1'b0;
    end else if (hostSel && hostWr && isCtrl) begin
      dblMode <= ctrlBits[0];
      txEn    <= ctrlBits[1];
      rxEn    <= ctrlBits[2];
    end
  end

  // Flags. The set and clear conditions of each flag are mutually exclusive.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txEmpty <= 1'b1;
      rxFull  <= 1'b0;
    end else begin
      if (txCommit)    txEmpty <= 1'b0;
      else if (takeOk) txEmpty <= 1'b1;
      if (pushOk)         rxFull <= 1'b1;
      else if (rxRelease) rxFull <= 1'b0;
    end
  end

  assign txReq = txEn && txEmpty;
  assign rxReq = rxEn && rxFull;

  // Registered request pins.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqTxN <= 1'b1;
      reqRxN <= 1'b1;
    end else if (dblMode) begin
      reqTxN <= !txReq;
      reqRxN <= !rxReq;
    end else begin
      reqTxN <= !(txReq || rxReq);
      reqRxN <= 1'b1;
    end
  end

  always_comb begin
    ctrlWord           = '0;
    ctrlWord[DBL_BIT]  = dblMode;
    ctrlWord[TXEN_BIT] = txEn;
    ctrlWord[RXEN_BIT] = rxEn;
    statWord           = '0;
    statWord[TXE_BIT]  = txEmpty;
    statWord[RXF_BIT]  = rxFull;
  end
endmodule

// File: rtl/host_req_dp.sv
module host_req_dp
  import host_req_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SLOTS  = 4,
  localparam int IDX_W  = $clog2(SLOTS),
  localparam int FRAME_W = DATA_W * SLOTS
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          strobe,
  input  logic [IDX_W-1:0]   slotIdx,
  input  logic [DATA_W-1:0]  hostWdata,
  input  logic [DATA_W-1:0]  ctrlWord,
  input  logic [DATA_W-1:0]  statWord,
  input  logic [FRAME_W-1:0] coreRxData,
  output logic [FRAME_W-1:0] coreTxData,
  output logic [DATA_W-1:0]  hostRdata
);
  logic [DATA_W-1:0] txSlot [SLOTS];
  logic [DATA_W-1:0] rxSlot [SLOTS];

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        txSlot[i] <= '0;
        rxSlot[i] <= '0;
      end else begin
        if (strobe.txWrite && (slotIdx == IDX_W'(i))) txSlot[i] <= hostWdata;
        if (strobe.rxLoad) rxSlot[i] <= coreRxData[i*DATA_W +: DATA_W];
      end
    end
    assign coreTxData[i*DATA_W +: DATA_W] = txSlot[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              hostRdata <= '0;
    else if (strobe.rdSlot) hostRdata <= rxSlot[slotIdx];
    else if (strobe.rdCtrl) hostRdata <= ctrlWord;
    else if (strobe.rdStat) hostRdata <= statWord;
  end
endmodule

// File: rtl/host_req_port.sv
module host_req_port
  import host_req_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SLOTS  = 4,
  localparam int IDX_W   = $clog2(SLOTS),
  localparam int ADDR_W  = IDX_W + 1,
  localparam int FRAME_W = DATA_W * SLOTS
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostSel,
  input  logic               hostWr,
  input  logic [ADDR_W-1:0]  hostAddr,
  input  logic [DATA_W-1:0]  hostWdata,
  output logic [DATA_W-1:0]  hostRdata,
  output logic               coreTxValid,
  output logic [FRAME_W-1:0] coreTxData,
  input  logic               coreTxTake,
  output logic               coreRxReady,
  input  logic [FRAME_W-1:0] coreRxData,
  input  logic               coreRxPush,
  output logic               reqTxN,
  output logic               reqRxN
);
  dpStrobe_t         strobe;
  logic [DATA_W-1:0] ctrlWord;
  logic [DATA_W-1:0] statWord;
  logic              dblMode;
  logic              txEn;
  logic              rxEn;
  logic              txEmpty;
  logic              rxFull;

  host_req_ctrl #(.DATA_W(DATA_W), .SLOTS(SLOTS)) ctrl_i (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWr(hostWr), .hostAddr(hostAddr),
    .ctrlBits({hostWdata[RXEN_BIT], hostWdata[TXEN_BIT], hostWdata[DBL_BIT]}),
    .coreTxTake(coreTxTake), .coreRxPush(coreRxPush), .strobe(strobe),
    .ctrlWord(ctrlWord), .statWord(statWord), .dblMode(dblMode), .txEn(txEn),
    .rxEn(rxEn), .txEmpty(txEmpty), .rxFull(rxFull), .reqTxN(reqTxN), .reqRxN(reqRxN)
  );

  host_req_dp #(.DATA_W(DATA_W), .SLOTS(SLOTS)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .slotIdx(hostAddr[IDX_W-1:0]),
    .hostWdata(hostWdata), .ctrlWord(ctrlWord), .statWord(statWord),
    .coreRxData(coreRxData), .coreTxData(coreTxData), .hostRdata(hostRdata)
  );

  assign coreTxValid = !txEmpty;
  assign coreRxReady = !rxFull;
endmodule

// File: rtl/host_req_chk.sv
module host_req_chk #(
  parameter int DATA_W = 16,
  parameter int SLOTS  = 4,
  localparam int IDX_W   = $clog2(SLOTS),
  localparam int ADDR_W  = IDX_W + 1,
  localparam int FRAME_W = DATA_W * SLOTS
) (
  input logic               clk,
  input logic               rstN,
  input logic               hostSel,
  input logic               hostWr,
  input logic [ADDR_W-1:0]  hostAddr,
  input logic               coreRxPush,
  input logic [FRAME_W-1:0] coreTxData,
  input logic               reqTxN,
  input logic               reqRxN,
  input logic               dblMode,
  input logic               txEn,
  input logic               rxEn,
  input logic               txEmpty,
  input logic               rxFull
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SLOTS - 1);

  // R3: writing the last transmit slot while empty commits the frame
  p_tx_commit_r3: assert property (@(posedge clk) disable iff (!rstN)
    (hostSel && hostWr && hostAddr[ADDR_W-1] && hostAddr[IDX_W-1:0] == LAST_IDX && txEmpty)
    |=> !txEmpty);

  // R5: a transmit write while a frame is pending leaves the data untouched
  p_tx_ignore_r5: assert property (@(posedge clk) disable iff (!rstN)
    (hostSel && hostWr && hostAddr[ADDR_W-1] && !txEmpty) |=> $stable(coreTxData));

  // R6: reading the last receive slot while full releases the flag
  p_rx_release_r6: assert property (@(posedge clk) disable iff (!rstN)
    (hostSel && !hostWr && hostAddr[ADDR_W-1] && hostAddr[IDX_W-1:0] == LAST_IDX && rxFull)
    |=> !rxFull);

  // R7: a push while full keeps the flag set
  p_push_refused_r7: assert property (@(posedge clk) disable iff (!rstN)
    (coreRxPush && rxFull && !(hostSel && !hostWr && hostAddr[ADDR_W-1])) |=> rxFull);

  // R9: with both enables clear, neither pin asserts
  p_pins_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!txEn && !rxEn) |=> (reqTxN && reqRxN));

  // R10: outside double mode the second pin stays high
  p_single_rx_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    !dblMode |=> reqRxN);
endmodule

bind host_req_port host_req_chk #(.DATA_W(DATA_W), .SLOTS(SLOTS)) chk_i (
  .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWr(hostWr), .hostAddr(hostAddr),
  .coreRxPush(coreRxPush), .coreTxData(coreTxData), .reqTxN(reqTxN), .reqRxN(reqRxN),
  .dblMode(dblMode), .txEn(txEn), .rxEn(rxEn), .txEmpty(txEmpty), .rxFull(rxFull)
);

// File: tb/host_req_port_tb.sv
module host_req_port_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostSel = 1'b0;
  logic        hostWr = 1'b0;
  logic [2:0]  hostAddr = '0;
  logic [15:0] hostWdata = '0;
  logic [15:0] hostRdata;
  logic        coreTxValid;
  logic [63:0] coreTxData;
  logic        coreTxTake = 1'b0;
  logic        coreRxReady;
  logic [63:0] coreRxData = '0;
  logic        coreRxPush = 1'b0;
  logic        reqTxN;
  logic        reqRxN;

  int compared = 0;
  int mismatched = 0;
  bit teCur;
  bit rfCur;

  always #(CLK_PERIOD/2) clk = ~clk;

  host_req_port dut_i (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWr(hostWr), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .coreTxValid(coreTxValid),
    .coreTxData(coreTxData), .coreTxTake(coreTxTake), .coreRxReady(coreRxReady),
    .coreRxData(coreRxData), .coreRxPush(coreRxPush), .reqTxN(reqTxN), .reqRxN(reqRxN)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    hostSel = 1'b1; hostWr = 1'b1; hostAddr = a; hostWdata = d;
    @(negedge clk);
    hostSel = 1'b0; hostWr = 1'b0;
  endtask

  task automatic hostRead(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    hostSel = 1'b1; hostWr = 1'b0; hostAddr = a;
    @(negedge clk);
    hostSel = 1'b0;
    d = hostRdata;
  endtask

  task automatic coreTake();
    @(negedge clk); coreTxTake = 1'b1;
    @(negedge clk); coreTxTake = 1'b0;
  endtask

  task automatic corePush(input logic [63:0] d);
    @(negedge clk); coreRxPush = 1'b1; coreRxData = d;
    @(negedge clk); coreRxPush = 1'b0;
  endtask

  task automatic setFlags(input bit te, input bit rf);
    logic [15:0] dummy;
    if (te != teCur) begin
      if (te) coreTake(); else hostWrite(3'd7, 16'h0BAD);
      teCur = te;
    end
    if (rf != rfCur) begin
      if (rf) corePush(64'h1); else hostRead(3'd7, dummy);
      rfCur = rf;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    logic [63:0] frameA;
    logic [63:0] frameB;
    frameA = 64'h4444_3333_2222_1111;
    frameB = 64'hDDDD_CCCC_BBBB_AAAA;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 reqTxN", reqTxN, 1);
    check("R1 reqRxN", reqRxN, 1);
    check("R1 coreTxValid", coreTxValid, 0);
    check("R1 coreRxReady", coreRxReady, 1);
    hostRead(3'd1, rd); check("R1 status", rd, 16'h4000);
    hostRead(3'd0, rd); check("R1 ctrl", rd, 16'h0000);

    // R2 control readback masks unused bits
    hostWrite(3'd0, 16'hFFFF);
    hostRead(3'd0, rd); check("R2 ctrl readback", rd, 16'hE000);
    hostWrite(3'd0, 16'h0000);

    // R3 fill transmit slots
    for (int i = 0; i < 4; i++) begin
      hostWrite(3'(4 + i), frameA[i*16 +: 16]);
      check("R3 valid during fill", coreTxValid, (i == 3) ? 1 : 0);
    end
    check("R3 tx frame", coreTxData, frameA);
    hostRead(3'd1, rd); check("R2 status tx pending", rd, 16'h0000);

    // R5 write while pending is ignored
    hostWrite(3'd5, 16'hFFFF);
    hostWrite(3'd7, 16'hEEEE);
    check("R5 tx data kept", coreTxData, frameA);
    check("R5 still valid", coreTxValid, 1);

    // R4 core take
    coreTake();
    check("R4 empty after take", coreTxValid, 0);

    // R6 and R7 receive path
    corePush(frameA);
    check("R6 not ready after push", coreRxReady, 0);
    hostRead(3'd1, rd); check("R6 status full", rd, 16'hC000);
    corePush(frameB);
    check("R7 still full", coreRxReady, 0);
    for (int i = 0; i < 4; i++) begin
      hostRead(3'(4 + i), rd);
      check("R6/R7 rx word", rd, frameA[i*16 +: 16]);
      check("R6 ready after read", coreRxReady, (i == 3) ? 1 : 0);
    end
    corePush(frameB);
    hostRead(3'd4, rd); check("R6 new frame word0", rd, frameB[15:0]);
    hostRead(3'd7, rd); check("R6 new frame word3", rd, frameB[63:48]);

    // R8 one clock latency of the transmit pin
    teCur = 1'b1; rfCur = 1'b0;
    hostWrite(3'd0, 16'h6000);
    check("R8 pin not yet", reqTxN, 1);
    @(negedge clk);
    check("R8 pin after one clock", reqTxN, 0);

    // R8 R9 R10 sweep of control settings against flag states
    for (int c = 0; c < 8; c++) begin
      for (int f = 0; f < 4; f++) begin
        bit te, rf, dbl, tEn, rEn, tReq, rReq, expTx, expRx;
        te = f[0]; rf = f[1];
        dbl = c[0]; tEn = c[1]; rEn = c[2];
        hostWrite(3'd0, 16'(c) << 13);
        setFlags(te, rf);
        @(negedge clk);
        tReq = tEn & te; rReq = rEn & rf;
        expTx = dbl ? !tReq : !(tReq | rReq);
        expRx = dbl ? !rReq : 1'b1;
        check(dbl ? "R8 tx pin" : "R10 merged pin", reqTxN, expTx);
        check(dbl ? "R9 rx pin" : "R10 rx idle", reqRxN, expRx);
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule